// File: doc/BRIEF.md
# Secure and Privileged Register Access Filter

This block guards a small bank of configuration registers that sits behind a simple single-cycle register bus. Every request carries two attributes, secure and privileged, and the chip supplies a global security-enable input. For each request the block looks up the target register and decides whether the access goes through. The decision uses the register's access class, the two attributes, the global enable and the live group-protection bits. A refused read returns zero and a refused write leaves storage unchanged.

Refusals come in two kinds. A refusal caused by a missing secure attribute is reported as a one-cycle illegal-access pulse. A refusal caused only by a missing privileged attribute, by a disabled register, or by an unmapped offset is silent. The pulse feeds a sticky interrupt line that has its own enable and clear inputs.

The block owns the group-protection register that holds the per-group security bits. Simple placeholder storage stands in for the registers behind the filter. The lock and page-protection registers are set-only, and the key register is write-only.

Top module: `secacc_filter`

## Requirements
- R1: A refused read returns 0 and a refused write changes nothing. Reads of unmapped or misaligned offsets return 0, writes to them are ignored, and no event is raised. Bits above a register's width read as 0.
- R2: `ill_event` is high for exactly the one cycle after a request that is refused for lacking the secure attribute. It is never raised for a refusal caused only by privilege, by disabled security or by an unmapped offset.
- R3: The group-protection register at 0x00 resets to 0 and has 4 bits. Bit 3 guards the FPU mask, bit 2 guards the memory group, bit 1 guards the fault-routing register, and bit 0 is plain storage. With `sec_en`=1 any access may read it, but only secure writes land; a non-secure write is dropped and raises the event. With `sec_en`=0 it reads 0, ignores writes and raises no event.
- R4: The FPU interrupt-mask register at 0x08 resets to 0x1F and has 6 read/write enable bits. From bit 0 upward they are: invalid-op, divide-by-zero, underflow, overflow, input-denormal, inexact. With `sec_en`=1 and group bit 3 set, a non-secure access is refused and raises the event.
- R5: When `sec_en`=1, group bit 1 restricts the fault-routing register (0x14, 4 bits) to secure access. Group bit 2 does the same for the memory group: control/status (0x18, 2 bits), key (0x1C, 8 bits, write-only, reads 0) and page-protect (0x20 and 0x24, 32 bits each). A refused non-secure access raises the event. With the group bit clear, non-secure access is allowed.
- R6: Registers 0x08, 0x0C and 0x10 accept privileged accesses only. An unprivileged access is refused with no event, unless it also fails a security check, in which case the event is raised.
- R7: The secure lock register at 0x10 (3 bits) needs the secure attribute when `sec_en`=1; a non-secure access is refused and raises the event. With `sec_en`=0 it reads 0, ignores writes and raises no event.
- R8: The non-secure lock register (0x0C, 2 bits), the secure lock register (0x10) and both page-protect registers are set-only. A written 1 sets the bit, a written 0 has no effect, and only reset clears a bit.
- R9: With `sec_en`=0, the FPU mask and the group-protected registers ignore the secure attribute, whatever the group bits hold.
- R10: `irq` is set at the edge that raises `ill_event` while `irq_en`=1. It stays high until `irq_clr` is sampled high. A new event in the same cycle as `irq_clr` wins.
- R11: `bus_rdata` is registered. It carries the result of a read in the cycle after the read and is 0 after any non-read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_en | input | 1 | Global security enable |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_secure | input | 1 | Request carries the secure attribute |
| bus_priv | input | 1 | Request carries the privileged attribute |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read |
| ill_event | output | 1 | One-cycle illegal-access pulse |
| irq_en | input | 1 | Lets events set the interrupt |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Sticky illegal-access interrupt |

## Verification
The hardest situations to reach are the ones where the live configuration reshapes the rule for a later access. Examples are a group bit written by a secure access that then refuses a non-secure one, and group bits left set while `sec_en` drops so that they must stop mattering. Others are a refused write that must leave set-only storage untouched, and a request that fails privilege and security together. The stimulus table reaches these by ordering writes and reads so that each read observes state built by earlier entries, and it flips `sec_en` and the group bits partway through. Directed steps afterwards drive the interrupt's set-versus-clear collision and the idle-cycle read-data behaviour.

// File: rtl/secacc_pkg.sv
package secacc_pkg;

   typedef enum logic [3:0] {
      RID_NONE,
      RID_SECCFG,
      RID_FPU,
      RID_NSLOCK,
      RID_SLOCK,
      RID_FAULT,
      RID_CSR,
      RID_KEY,
      RID_PAGE
   } rid_e;

   // group-protection bit positions (decoded by the rule checker)
   localparam int unsigned GRP_BITS  = 4;
   localparam int unsigned GRP_FPU   = 3;
   localparam int unsigned GRP_MEM   = 2;
   localparam int unsigned GRP_FAULT = 1;

   // byte offsets
   localparam int unsigned OFF_SECCFG = 'h00;
   localparam int unsigned OFF_FPU    = 'h08;
   localparam int unsigned OFF_NSLOCK = 'h0C;
   localparam int unsigned OFF_SLOCK  = 'h10;
   localparam int unsigned OFF_FAULT  = 'h14;
   localparam int unsigned OFF_CSR    = 'h18;
   localparam int unsigned OFF_KEY    = 'h1C;
   localparam int unsigned OFF_PAGE   = 'h20;

endpackage

// File: rtl/secacc_decode.sv
module secacc_decode
   import secacc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned NUM_PAGE = 2,
   localparam int unsigned PIDX_W  = (NUM_PAGE > 1) ? $clog2(NUM_PAGE) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output rid_e              rid,
   output logic [PIDX_W-1:0] pidx
);

   localparam int unsigned TOP_OFF = OFF_PAGE + 4 * (NUM_PAGE - 1);

   generate
      if (TOP_OFF >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the page-protect registers");
      end
   endgenerate

   always_comb begin
      rid  = RID_NONE;
      pidx = '0;
      if      (addr == ADDR_W'(OFF_SECCFG)) rid = RID_SECCFG;
      else if (addr == ADDR_W'(OFF_FPU))    rid = RID_FPU;
      else if (addr == ADDR_W'(OFF_NSLOCK)) rid = RID_NSLOCK;
      else if (addr == ADDR_W'(OFF_SLOCK))  rid = RID_SLOCK;
      else if (addr == ADDR_W'(OFF_FAULT))  rid = RID_FAULT;
      else if (addr == ADDR_W'(OFF_CSR))    rid = RID_CSR;
      else if (addr == ADDR_W'(OFF_KEY))    rid = RID_KEY;
      else begin
         for (int i = 0; i < NUM_PAGE; i++) begin
            if (addr == ADDR_W'(OFF_PAGE + 4 * i)) begin
               rid  = RID_PAGE;
               pidx = PIDX_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/secacc_rule.sv
module secacc_rule
   import secacc_pkg::*;
(
   input  rid_e                rid,
   input  logic                write,
   input  logic                secure,
   input  logic                priv,
   input  logic                sec_en,
   input  logic [GRP_BITS-1:0] grp,
   output logic                allow,
   output logic                illegal
);

   logic sec_viol;
   logic priv_viol;
   logic silent;

   always_comb begin
      sec_viol  = 1'b0;
      priv_viol = 1'b0;
      silent    = 1'b0;
      unique case (rid)
         RID_SECCFG: begin
            silent   = !sec_en;
            sec_viol = sec_en && write && !secure;
         end
         RID_FPU: begin
            priv_viol = !priv;
            sec_viol  = sec_en && grp[GRP_FPU] && !secure;
         end
         RID_NSLOCK: priv_viol = !priv;
         RID_SLOCK: begin
            priv_viol = !priv;
            silent    = !sec_en;
            sec_viol  = sec_en && !secure;
         end
         RID_FAULT: sec_viol = sec_en && grp[GRP_FAULT] && !secure;
         RID_CSR, RID_KEY, RID_PAGE:
            sec_viol = sec_en && grp[GRP_MEM] && !secure;
         default: silent = 1'b1;
      endcase
      allow   = !(sec_viol || priv_viol || silent);
      illegal = sec_viol;
   end

endmodule

// File: rtl/secacc_regs.sv
module secacc_regs
   import secacc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned FPU_BITS    = 6,
   parameter logic [FPU_BITS-1:0] FPU_RST = 6'h1F,
   parameter int unsigned NSLOCK_BITS = 2,
   parameter int unsigned SLOCK_BITS  = 3,
   parameter int unsigned FAULT_BITS  = 4,
   parameter int unsigned CSR_BITS    = 2,
   parameter int unsigned KEY_BITS    = 8,
   parameter int unsigned PAGE_W      = 32,
   parameter int unsigned NUM_PAGE    = 2,
   localparam int unsigned PIDX_W     = (NUM_PAGE > 1) ? $clog2(NUM_PAGE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  rid_e                rid,
   input  logic [PIDX_W-1:0]   pidx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rval,
   output logic [GRP_BITS-1:0] grp
);

   generate
      if (PAGE_W > DATA_W || FPU_BITS > DATA_W || KEY_BITS > DATA_W ||
          FAULT_BITS > DATA_W || GRP_BITS > DATA_W) begin : g_bad_width
         $error("a register is wider than the data bus");
      end
   endgenerate

   logic [GRP_BITS-1:0]    seccfg_q;
   logic [FPU_BITS-1:0]    fpu_q;
   logic [NSLOCK_BITS-1:0] nslock_q;
   logic [SLOCK_BITS-1:0]  slock_q;
   logic [FAULT_BITS-1:0]  fault_q;
   logic [CSR_BITS-1:0]    csr_q;
   logic [KEY_BITS-1:0]    key_q;
   logic [PAGE_W-1:0]      page_q [NUM_PAGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seccfg_q <= '0;
         fpu_q    <= FPU_RST;
         nslock_q <= '0;
         slock_q  <= '0;
         fault_q  <= '0;
         csr_q    <= '0;
         key_q    <= '0;
      end else if (we) begin
         unique case (rid)
            RID_SECCFG: seccfg_q <= wdata[GRP_BITS-1:0];
            RID_FPU:    fpu_q    <= wdata[FPU_BITS-1:0];
            RID_NSLOCK: nslock_q <= nslock_q | wdata[NSLOCK_BITS-1:0];
            RID_SLOCK:  slock_q  <= slock_q | wdata[SLOCK_BITS-1:0];
            RID_FAULT:  fault_q  <= wdata[FAULT_BITS-1:0];
            RID_CSR:    csr_q    <= wdata[CSR_BITS-1:0];
            RID_KEY:    key_q    <= wdata[KEY_BITS-1:0];
            default: ;
         endcase
      end
   end

   // set-only page-protect registers, one per page bank
   generate
      for (genvar g = 0; g < NUM_PAGE; g++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               page_q[g] <= '0;
            else if (we && rid == RID_PAGE && pidx == PIDX_W'(g))
               page_q[g] <= page_q[g] | wdata[PAGE_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      rval = '0;
      unique case (rid)
         RID_SECCFG: rval = DATA_W'(seccfg_q);
         RID_FPU:    rval = DATA_W'(fpu_q);
         RID_NSLOCK: rval = DATA_W'(nslock_q);
         RID_SLOCK:  rval = DATA_W'(slock_q);
         RID_FAULT:  rval = DATA_W'(fault_q);
         RID_CSR:    rval = DATA_W'(csr_q);
         RID_PAGE:   rval = (int'(pidx) < NUM_PAGE) ? DATA_W'(page_q[pidx]) : '0;
         default:    rval = '0;   // key is write-only
      endcase
   end

   assign grp = seccfg_q;

   // R8: lock bits never clear outside reset
   a_r8_nslock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((nslock_q & $past(nslock_q)) == $past(nslock_q)));
   a_r8_slock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((slock_q & $past(slock_q)) == $past(slock_q)));
   // R3: the group register only changes on a permitted write
   a_r3_seccfg_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && rid == RID_SECCFG) |=> $stable(seccfg_q));

endmodule

// File: rtl/secacc_irq.sv
module secacc_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic illegal,
   input  logic irq_en,
   input  logic irq_clr,
   output logic ill_event,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ill_event <= 1'b0;
         irq       <= 1'b0;
      end else begin
         ill_event <= illegal;
         if (illegal && irq_en) irq <= 1'b1;
         else if (irq_clr)      irq <= 1'b0;
      end
   end

   // R10: interrupt holds without a clear
   a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   // R10: interrupt rises only together with an event
   a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ill_event);

endmodule

// File: rtl/secacc_filter.sv
module secacc_filter
   import secacc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_PAGE = 2,
   localparam int unsigned PIDX_W  = (NUM_PAGE > 1) ? $clog2(NUM_PAGE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_en,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_secure,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ill_event,
   input  logic              irq_en,
   input  logic              irq_clr,
   output logic              irq
);

   rid_e                rid;
   logic [PIDX_W-1:0]   pidx;
   logic                acc_allow;
   logic                acc_illegal;
   logic [DATA_W-1:0]   rval;
   logic [GRP_BITS-1:0] grp;

   secacc_decode #(.ADDR_W(ADDR_W), .NUM_PAGE(NUM_PAGE)) u_dec (
      .addr (bus_addr),
      .rid  (rid),
      .pidx (pidx)
   );

   secacc_rule u_rule (
      .rid     (rid),
      .write   (bus_write),
      .secure  (bus_secure),
      .priv    (bus_priv),
      .sec_en  (sec_en),
      .grp     (grp),
      .allow   (acc_allow),
      .illegal (acc_illegal)
   );

   secacc_regs #(.DATA_W(DATA_W), .NUM_PAGE(NUM_PAGE)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_valid && bus_write && acc_allow),
      .rid   (rid),
      .pidx  (pidx),
      .wdata (bus_wdata),
      .rval  (rval),
      .grp   (grp)
   );

   secacc_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .illegal   (bus_valid && acc_illegal),
      .irq_en    (irq_en),
      .irq_clr   (irq_clr),
      .ill_event (ill_event),
      .irq       (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else
         bus_rdata <= (bus_valid && !bus_write && acc_allow) ? rval : '0;
   end

   // R1: refused reads come back as zero
   a_r1_refused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && !acc_allow) |=> (bus_rdata == '0));
   // R2: events only follow non-secure requests while security is on
   a_r2_event_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ill_event |-> $past(bus_valid && !bus_secure && sec_en));
   // R6: a secure but unprivileged access is refused silently
   a_r6_priv_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_secure && !bus_priv &&
       (rid == RID_NSLOCK || rid == RID_SLOCK || rid == RID_FPU)) |=> !ill_event);
   // R11: idle cycles leave zero on the read data
   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> (bus_rdata == '0));

endmodule

// File: tb/tb_secacc_filter.sv
module tb_secacc_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_en = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_secure = 1'b0;
   logic        bus_priv = 1'b0;
   logic [31:0] bus_rdata;
   logic        ill_event;
   logic        irq_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   secacc_filter dut (
      .clk(clk), .rst_n(rst_n), .sec_en(sec_en),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_priv(bus_priv),
      .bus_rdata(bus_rdata), .ill_event(ill_event),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
   );

   typedef struct packed {
      logic        w;
      logic [5:0]  a;
      logic [31:0] d;
      logic        s;
      logic        p;
      logic        e;
      logic [31:0] x;
      logic        v;
      logic [3:0]  r;
   } vec_t;

   localparam int NV = 56;
   // fields: write, offset, wdata, secure, priv, sec_en, expected rdata, expected event, requirement
   localparam vec_t TBL [NV] = '{
      '{1'b0, 6'h00, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd3},  // R3 reset 0
      '{1'b0, 6'h08, 32'h0,        1'b1, 1'b1, 1'b1, 32'h1F,       1'b0, 4'd4},  // R4 reset 1F
      '{1'b1, 6'h00, 32'hF,        1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'd3},  // R3 ns write
      '{1'b0, 6'h00, 32'h0,        1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 4'd3},
      '{1'b1, 6'h00, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd3},
      '{1'b0, 6'h00, 32'h0,        1'b0, 1'b0, 1'b1, 32'hF,        1'b0, 4'd3},  // R3 anyone reads
      '{1'b0, 6'h08, 32'h0,        1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'd4},
      '{1'b1, 6'h08, 32'h15,       1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'd4},
      '{1'b0, 6'h08, 32'h0,        1'b1, 1'b1, 1'b1, 32'h1F,       1'b0, 4'd1},  // R1 write dropped
      '{1'b1, 6'h08, 32'hFFFFFFEA, 1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd4},
      '{1'b0, 6'h08, 32'h0,        1'b1, 1'b1, 1'b1, 32'h2A,       1'b0, 4'd4},
      '{1'b0, 6'h08, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd6},  // R6
      '{1'b1, 6'h0C, 32'h3,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd6},
      '{1'b0, 6'h0C, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd6},
      '{1'b1, 6'h0C, 32'h1,        1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 4'd8},  // R8
      '{1'b1, 6'h0C, 32'h0,        1'b0, 1'b1, 1'b1, 32'h0,        1'b0, 4'd8},
      '{1'b0, 6'h0C, 32'h0,        1'b0, 1'b1, 1'b1, 32'h1,        1'b0, 4'd8},
      '{1'b1, 6'h10, 32'h7,        1'b0, 1'b1, 1'b1, 32'h0,        1'b1, 4'd7},  // R7
      '{1'b0, 6'h10, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd7},
      '{1'b1, 6'h10, 32'h5,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd7},
      '{1'b1, 6'h10, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd8},
      '{1'b0, 6'h10, 32'h0,        1'b1, 1'b1, 1'b1, 32'h5,        1'b0, 4'd8},
      '{1'b1, 6'h14, 32'hF,        1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'd5},  // R5
      '{1'b0, 6'h14, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b1, 6'h14, 32'h9,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b0, 6'h14, 32'h0,        1'b1, 1'b1, 1'b1, 32'h9,        1'b0, 4'd5},
      '{1'b1, 6'h20, 32'hA5,       1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'd5},
      '{1'b0, 6'h20, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b1, 6'h24, 32'h80000001, 1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b0, 6'h24, 32'h0,        1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'd5},
      '{1'b0, 6'h24, 32'h0,        1'b1, 1'b0, 1'b1, 32'h80000001, 1'b0, 4'd5},
      '{1'b1, 6'h24, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd8},
      '{1'b0, 6'h24, 32'h0,        1'b1, 1'b0, 1'b1, 32'h80000001, 1'b0, 4'd8},
      '{1'b1, 6'h1C, 32'hCA,       1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b0, 6'h1C, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},  // key write-only
      '{1'b1, 6'h18, 32'h3,        1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'd5},
      '{1'b1, 6'h18, 32'h3,        1'b1, 1'b0, 1'b1, 32'h0,        1'b0, 4'd5},
      '{1'b0, 6'h18, 32'h0,        1'b1, 1'b0, 1'b1, 32'h3,        1'b0, 4'd5},
      '{1'b0, 6'h3C, 32'h0,        1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 4'd1},  // R1 unmapped
      '{1'b1, 6'h3C, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b1, 32'h0,        1'b0, 4'd1},
      '{1'b0, 6'h02, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd1},  // misaligned
      '{1'b0, 6'h14, 32'h0,        1'b0, 1'b0, 1'b0, 32'h9,        1'b0, 4'd9},  // R9
      '{1'b1, 6'h08, 32'h3,        1'b0, 1'b1, 1'b0, 32'h0,        1'b0, 4'd9},
      '{1'b0, 6'h08, 32'h0,        1'b0, 1'b1, 1'b0, 32'h3,        1'b0, 4'd9},
      '{1'b0, 6'h08, 32'h0,        1'b0, 1'b0, 1'b0, 32'h0,        1'b0, 4'd6},
      '{1'b0, 6'h00, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 4'd3},
      '{1'b1, 6'h00, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 4'd3},
      '{1'b0, 6'h10, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
      '{1'b1, 6'h10, 32'h2,        1'b1, 1'b1, 1'b0, 32'h0,        1'b0, 4'd7},
      '{1'b0, 6'h00, 32'h0,        1'b1, 1'b1, 1'b1, 32'hF,        1'b0, 4'd3},
      '{1'b0, 6'h10, 32'h0,        1'b1, 1'b1, 1'b1, 32'h5,        1'b0, 4'd7},
      '{1'b1, 6'h00, 32'h0,        1'b1, 1'b1, 1'b1, 32'h0,        1'b0, 4'd3},
      '{1'b0, 6'h14, 32'h0,        1'b0, 1'b0, 1'b1, 32'h9,        1'b0, 4'd5},
      '{1'b0, 6'h08, 32'h0,        1'b0, 1'b1, 1'b1, 32'h3,        1'b0, 4'd4},
      '{1'b1, 6'h10, 32'h2,        1'b0, 1'b0, 1'b1, 32'h0,        1'b1, 4'd6},  // both fail
      '{1'b0, 6'h10, 32'h0,        1'b1, 1'b1, 1'b1, 32'h5,        1'b0, 4'd6}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic req(input logic w, input logic [5:0] a, input logic [31:0] d,
                      input logic s, input logic p, input logic e);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
      bus_secure = s; bus_priv = p; sec_en = e;
      @(posedge clk); #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset rdata", bus_rdata, 32'h0);
      check("R2 reset event", {31'b0, ill_event}, 32'h0);
      check("R10 reset irq", {31'b0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         req(TBL[i].w, TBL[i].a, TBL[i].d, TBL[i].s, TBL[i].p, TBL[i].e);
         check($sformatf("R%0d rdata vec %0d", TBL[i].r, i), bus_rdata, TBL[i].x);
         check($sformatf("R%0d event vec %0d", TBL[i].r, i), {31'b0, ill_event}, {31'b0, TBL[i].v});
      end

      // R11: read result followed by an idle cycle
      req(1'b0, 6'h0C, 32'h0, 1'b1, 1'b1, 1'b1);
      check("R11 read data", bus_rdata, 32'h1);
      idle();
      check("R11 idle zero", bus_rdata, 32'h0);
      check("R10 irq off while disabled", {31'b0, irq}, 32'h0);

      // R10 / R2: event sets the interrupt, pulse is one cycle
      @(negedge clk); irq_en = 1'b1;
      req(1'b1, 6'h10, 32'h1, 1'b0, 1'b1, 1'b1);
      check("R2 pulse high", {31'b0, ill_event}, 32'h1);
      check("R10 irq set", {31'b0, irq}, 32'h1);
      idle();
      check("R2 pulse one cycle", {31'b0, ill_event}, 32'h0);
      idle(); idle();
      check("R10 irq held", {31'b0, irq}, 32'h1);
      @(negedge clk); irq_clr = 1'b1; bus_valid = 1'b0;
      @(posedge clk); #1;
      check("R10 irq cleared", {31'b0, irq}, 32'h0);
      // collision: event and clear together
      req(1'b0, 6'h10, 32'h0, 1'b0, 1'b1, 1'b1);
      check("R10 set beats clear", {31'b0, irq}, 32'h1);
      @(negedge clk); irq_en = 1'b0; bus_valid = 1'b0;
      @(posedge clk); #1;
      check("R10 cleared again", {31'b0, irq}, 32'h0);
      @(negedge clk); irq_clr = 1'b0;
      req(1'b0, 6'h10, 32'h0, 1'b0, 1'b1, 1'b1);
      check("R10 event without enable", {31'b0, irq}, 32'h0);
      check("R2 event without enable", {31'b0, ill_event}, 32'h1);
      idle();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule